// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic device. Ten dedicated input signals and eight I/O feedback signals are each expanded into a true line and a complement line. That gives 36 array lines. A configuration store holds one 36-bit connection row per product term. Each product term is the AND of the lines whose connection is closed.

There are 113 product terms in total. The first 102 feed eight OR gates in groups of unequal size. Eight more terms serve as per-output enables. The last three give a shared synchronous-preset term, a shared asynchronous-clear term and a clock term. The macrocells that consume these signals sit outside this block, and so do pin drivers and electrical timing.

The connection pattern is loaded one row per cycle over a parallel configuration bus. A synchronous reset models a bulk erase: it opens every connection. All results are captured in output registers on each rising clock edge.

Top module: `sop_array`

## Requirements
- R1: Array line 2*s carries signal s true and line 2*s+1 carries its complement. Signals 0 to 9 are `ded_i[0..9]` and signals 10 to 17 are `fb_i[0..7]`. In a connection row, bit value 1 means closed. A write with `cfg_we`=1 stores `cfg_row` as the row of term `cfg_addr`.
- R2: A product term is TRUE exactly when every line whose connection is closed is high.
- R3: A product term with every connection open evaluates TRUE for any input.
- R4: A product term with both the true and the complement line of any one signal closed evaluates FALSE for any input.
- R5: Sum terms occupy addresses 0 to 101. They are grouped to sums 0 to 7 with sizes 8, 10, 12, 14, 16, 16, 14, 12, taken in ascending address order. Group bases are therefore 0, 8, 18, 30, 44, 60, 76 and 90.
- R6: `sum_o[k]` is the OR of the product terms in group k.
- R7: The term at address 102+k drives `oe_o[k]`. Address 110 drives `preset_o`, address 111 drives `clear_o` and address 112 drives `clk_term_o`.
- R8: While `rst` is high, every output reads 0. On reset, every connection row is cleared to all-open (bulk erase).
- R9: Every output is registered. Each output reflects the inputs and the configuration present before the previous rising edge, so a row written at an edge affects outputs one edge later. Writes to addresses 113 to 127 change nothing.
- R10: A sum term whose row is fully closed contributes nothing to its OR, so a group made only of such terms yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset and bulk erase |
| cfg_we | input | 1 | Configuration row write strobe |
| cfg_addr | input | 7 | Product term address of the row write |
| cfg_row | input | 36 | Connection row, bit value 1 = closed |
| ded_i | input | 10 | Dedicated input signals |
| fb_i | input | 8 | I/O feedback signals |
| sum_o | output | 8 | Registered OR-group results |
| oe_o | output | 8 | Registered per-output enable terms |
| preset_o | output | 1 | Registered synchronous-preset term |
| clear_o | output | 1 | Registered asynchronous-clear term |
| clk_term_o | output | 1 | Registered clock term |

## Verification
Right after erase, every term should be TRUE. This shows the open-connection default and confirms that no group is wired to a constant.

Directed single-line rows are driven with each input polarity. These separate the true line from the complement line and confirm the position of each line. Rows that close both lines of one signal are driven with many input values; they must hold FALSE throughout.

A walking single open term on an otherwise fully closed sum plane identifies the group boundary of every OR gate.

Long stretches of sparse random rows, written to random addresses (some out of range) while the inputs change every cycle, mix all terms together. They expose errors in latency, in address decoding and in the order of groups.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int N_DED    = 10;
  localparam int N_FB     = 8;
  localparam int N_OUT    = 8;
  localparam int N_SUM_PT = 102;
  localparam int N_SPECIAL = 3;

  // size of the OR group feeding sum k
  function automatic int grp_size(input int k);
    case (k)
      0: return 8;
      1: return 10;
      2: return 12;
      3: return 14;
      4: return 16;
      5: return 16;
      6: return 14;
      default: return 12;
    endcase
  endfunction

  // first sum-term address of group k
  function automatic int grp_base(input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += grp_size(i);
    return acc;
  endfunction
endpackage

// File: rtl/sop_line_gen.sv
module sop_line_gen #(
  parameter int N_DED = 10,
  parameter int N_FB  = 8,
  localparam int N_SIG  = N_DED + N_FB,
  localparam int N_LINE = 2 * N_SIG
) (
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_FB-1:0]   fb_i,
  output logic [N_LINE-1:0] line_o
);
  logic [N_SIG-1:0] sig;
  assign sig = {fb_i, ded_i};

  for (genvar s = 0; s < N_SIG; s++) begin : g_pair
    assign line_o[2*s]   = sig[s];
    assign line_o[2*s+1] = ~sig[s];
  end
endmodule

// File: rtl/sop_pterm_array.sv
module sop_pterm_array #(
  parameter int N_LINE = 36,
  parameter int N_PT   = 113
) (
  input  logic [N_LINE-1:0]            line_i,
  input  logic [N_PT-1:0][N_LINE-1:0]  conn_i,
  output logic [N_PT-1:0]              pt_o
);
  // an open connection (0) masks its line to 1
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt_o[t] = &(~conn_i[t] | line_i);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane import sop_pkg::*; #(
  parameter int N_OUT    = 8,
  parameter int N_SUM_PT = 102
) (
  input  logic [N_SUM_PT-1:0] pt_i,
  output logic [N_OUT-1:0]    sum_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_or
    localparam int BASE = grp_base(k);
    localparam int SIZE = grp_size(k);
    assign sum_o[k] = |pt_i[BASE +: SIZE];
  end
endmodule

// File: rtl/sop_array.sv
module sop_array import sop_pkg::*; #(
  parameter int N_DED    = sop_pkg::N_DED,
  parameter int N_FB     = sop_pkg::N_FB,
  parameter int N_OUT    = sop_pkg::N_OUT,
  parameter int N_SUM_PT = sop_pkg::N_SUM_PT,
  localparam int N_LINE  = 2 * (N_DED + N_FB),
  localparam int N_PT    = N_SUM_PT + N_OUT + N_SPECIAL,
  localparam int ADDR_W  = $clog2(N_PT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [N_LINE-1:0] cfg_row,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_FB-1:0]   fb_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              preset_o,
  output logic              clear_o,
  output logic              clk_term_o
);
  localparam int PT_OE     = N_SUM_PT;
  localparam int PT_PRESET = N_SUM_PT + N_OUT;
  localparam int PT_CLEAR  = PT_PRESET + 1;
  localparam int PT_CLOCK  = PT_PRESET + 2;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_PT - 1);

  logic [N_PT-1:0][N_LINE-1:0] conn_q;
  logic [N_LINE-1:0]           line_w;
  logic [N_PT-1:0]             pt_w;
  logic [N_OUT-1:0]            sum_w;

  // connection store: reset is the bulk erase (all open)
  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= '0;
    end else if (cfg_we && (cfg_addr <= LAST_ADDR)) begin
      conn_q[cfg_addr] <= cfg_row;
    end
  end

  sop_line_gen #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
    .ded_i  (ded_i),
    .fb_i   (fb_i),
    .line_o (line_w)
  );

  sop_pterm_array #(.N_LINE(N_LINE), .N_PT(N_PT)) u_terms (
    .line_i (line_w),
    .conn_i (conn_q),
    .pt_o   (pt_w)
  );

  sop_or_plane #(.N_OUT(N_OUT), .N_SUM_PT(N_SUM_PT)) u_or (
    .pt_i  (pt_w[N_SUM_PT-1:0]),
    .sum_o (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o      <= '0;
      oe_o       <= '0;
      preset_o   <= 1'b0;
      clear_o    <= 1'b0;
      clk_term_o <= 1'b0;
    end else begin
      sum_o      <= sum_w;
      oe_o       <= pt_w[PT_OE +: N_OUT];
      preset_o   <= pt_w[PT_PRESET];
      clear_o    <= pt_w[PT_CLEAR];
      clk_term_o <= pt_w[PT_CLOCK];
    end
  end
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk import sop_pkg::*; #(
  localparam int N_LINE = 2 * (N_DED + N_FB),
  localparam int N_PT   = N_SUM_PT + N_OUT + N_SPECIAL,
  localparam int ADDR_W = $clog2(N_PT)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_we,
  input logic [ADDR_W-1:0]           cfg_addr,
  input logic [N_LINE-1:0]           cfg_row,
  input logic [N_PT-1:0][N_LINE-1:0] conn_q,
  input logic [N_PT-1:0]             pt_w,
  input logic [N_OUT-1:0]            sum_o,
  input logic [N_OUT-1:0]            oe_o,
  input logic                        preset_o,
  input logic                        clear_o,
  input logic                        clk_term_o
);
  localparam int PT_CLEAR = N_SUM_PT + N_OUT + 1;
  localparam int PT_CLOCK = N_SUM_PT + N_OUT + 2;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_PT - 1);

  function automatic logic has_conflict(input logic [N_LINE-1:0] r);
    for (int s = 0; s < N_LINE / 2; s++)
      if (r[2*s] && r[2*s+1]) return 1'b1;
    return 1'b0;
  endfunction

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum_o == '0 && oe_o == '0 && !preset_o && !clear_o
                    && !clk_term_o && conn_q == '0));

  // R1
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr <= LAST_ADDR) |=> conn_q[$past(cfg_addr)] == $past(cfg_row));

  // R9
  cfg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we || cfg_addr > LAST_ADDR) |=> $stable(conn_q));

  // R3
  open_true_chk: assert property (@(posedge clk) disable iff (rst)
    (conn_q[PT_CLOCK] == '0) |=> clk_term_o);

  // R4
  conflict_false_chk: assert property (@(posedge clk) disable iff (rst)
    has_conflict(conn_q[PT_CLEAR]) |=> !clear_o);

  for (genvar k = 0; k < N_OUT; k++) begin : g_grp
    localparam int BASE = grp_base(k);
    localparam int SIZE = grp_size(k);
    // R6
    or_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (pt_w[BASE +: SIZE] == '0) |=> !sum_o[k]);
    // R6
    or_one_chk: assert property (@(posedge clk) disable iff (rst)
      (pt_w[BASE +: SIZE] != '0) |=> sum_o[k]);
  end
endmodule

bind sop_array sop_array_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_row    (cfg_row),
  .conn_q     (conn_q),
  .pt_w       (pt_w),
  .sum_o      (sum_o),
  .oe_o       (oe_o),
  .preset_o   (preset_o),
  .clear_o    (clear_o),
  .clk_term_o (clk_term_o)
);

// File: tb/sop_array_tb_top.sv
`timescale 1ns/1ps
module sop_array_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [35:0] cfg_row = '0;
  logic [9:0]  ded = '0;
  logic [7:0]  fb = '0;
  logic [7:0]  sum_o, oe_o;
  logic        preset_o, clear_o, clk_term_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [35:0] cfg_m [113];
  int sizes [8] = '{8, 10, 12, 14, 16, 16, 14, 12};

  always #2 clk = ~clk;

  sop_array dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_row(cfg_row),
    .ded_i(ded), .fb_i(fb), .sum_o(sum_o), .oe_o(oe_o), .preset_o(preset_o),
    .clear_o(clear_o), .clk_term_o(clk_term_o)
  );

  function automatic logic term_val(input int t, input logic [9:0] d, input logic [7:0] f);
    for (int s = 0; s < 18; s++) begin
      logic v;
      v = (s < 10) ? d[s] : f[s-10];
      if (cfg_m[t][2*s] && !v) return 1'b0;
      if (cfg_m[t][2*s+1] && v) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model, wait an edge, compare at next negedge
  task automatic step(input logic we, input int addr, input logic [35:0] row,
                      input logic [9:0] d, input logic [7:0] f, input string tag);
    logic [7:0] e_sum, e_oe;
    logic [2:0] e_sp;
    int base;
    ded = d; fb = f; cfg_we = we; cfg_addr = addr[6:0]; cfg_row = row;
    base = 0;
    for (int k = 0; k < 8; k++) begin
      e_sum[k] = 1'b0;
      for (int j = 0; j < sizes[k]; j++) e_sum[k] = e_sum[k] | term_val(base + j, d, f);
      base += sizes[k];
      e_oe[k] = term_val(102 + k, d, f);
    end
    e_sp = {term_val(110, d, f), term_val(111, d, f), term_val(112, d, f)};
    if (we && addr < 113) cfg_m[addr] = row;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk({tag, " sum"}, sum_o, e_sum);
    chk({tag, " R7 oe"}, oe_o, e_oe);
    chk({tag, " R7 preset/clear/clock"}, {5'b0, preset_o, clear_o, clk_term_o}, {5'b0, e_sp});
  endtask

  function automatic logic [35:0] sparse_row();
    logic [63:0] a;
    a = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
    return a[35:0];
  endfunction

  initial begin
    for (int t = 0; t < 113; t++) cfg_m[t] = '0;
    repeat (3) @(negedge clk);
    // R8: outputs held at zero during reset
    chk("R8 reset sum", sum_o, 8'h00);
    chk("R8 reset oe", oe_o, 8'h00);
    chk("R8 reset special", {5'b0, preset_o, clear_o, clk_term_o}, 8'h00);
    rst = 1'b0;
    // R8 erase leaves all connections open, R3 open terms read TRUE
    step(1'b0, 0, '0, 10'h2A5, 8'h3C, "R8 erase R3");
    step(1'b0, 0, '0, 10'h000, 8'hFF, "R3");
    // R4: clock term closes both lines of signal 2
    step(1'b1, 112, 36'h30, 10'h000, 8'h00, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, 0, '0, 10'($urandom()), 8'($urandom()), "R4");
    // R9: out-of-range writes do nothing; latency is modelled on every step
    step(1'b1, 120, '0, 10'h3FF, 8'hFF, "R9");
    step(1'b1, 127, '0, 10'h001, 8'h00, "R9");
    step(1'b0, 0, '0, 10'h002, 8'h01, "R9");
    // R2: clear term = ded0 & ~ded1
    step(1'b1, 111, 36'h9, 10'h000, 8'h00, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 0, '0, 10'(i), 8'h00, "R2");
    // R1: preset term = complement of fb[2] (line 25)
    step(1'b1, 110, 36'h1 << 25, 10'h000, 8'h00, "R1");
    step(1'b0, 0, '0, 10'h000, 8'h00, "R1");
    step(1'b0, 0, '0, 10'h000, 8'h04, "R1");
    step(1'b1, 103, 36'h1 << 20, 10'h3FF, 8'h00, "R1");
    step(1'b0, 0, '0, 10'h000, 8'h01, "R1");
    step(1'b0, 0, '0, 10'h000, 8'h00, "R1");
    // R10: close every sum term fully
    for (int t = 0; t < 102; t++) step(1'b1, t, '1, 10'($urandom()), 8'($urandom()), "R10");
    for (int i = 0; i < 8; i++) step(1'b0, 0, '0, 10'($urandom()), 8'($urandom()), "R10");
    // R5: walk a single open term over group edges
    for (int k = 0; k < 8; k++) begin
      int b;
      b = 0;
      for (int i = 0; i < k; i++) b += sizes[i];
      step(1'b1, b, '0, 10'h000, 8'h00, "R5");
      step(1'b1, b, '1, 10'h000, 8'h00, "R5");
      step(1'b1, b + sizes[k] - 1, '0, 10'h000, 8'h00, "R5");
      step(1'b1, b + sizes[k] - 1, '1, 10'h000, 8'h00, "R5");
    end
    // R6: random sparse rows, random addresses, random inputs
    for (int i = 0; i < 600; i++)
      step(1'($urandom()), int'($urandom_range(0, 127)), sparse_row(),
           10'($urandom()), 8'($urandom()), "R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule